// File: doc/BRIEF.md
# ISA 16-bit Memory Window Decoder

This block sits on an ISA adapter card. It tells the host, early in each memory cycle, whether the addressed location belongs to the card's 16-bit memory window. The host only knows in time to run a 16-bit, one-wait-state transfer if the active-low 16-bit chip select is already settled when the address-latch strobe falls. For that reason the select is formed only from the early, unlatched upper address lines `la` (address bits 23 down to 17). The wider but later system address `sa` plays no part in it. A consequence is that the whole 128 KB block sharing those upper bits is treated as one bus width.

The upper lines are only valid while the strobe `bale` is high. The block therefore passes the live decode straight to the select while `bale` is high. While `bale` is high it also records, on each clock, the decode result and the system address. Once `bale` falls it stops recording, and it drives the select from the recorded hit until the next cycle opens. The recorded hit and the card-local address then feed the card's memory array. The array is enabled only for a read or write strobe inside a hit cycle.

The window base (as a 128 KB block index), its length in blocks, and whether it is a 16-bit window are parameters.

Top module: `isa_mem16_window`

## Requirements
- R1: A cycle hits the window when the block index `la` (address bits 23:17) satisfies BASE_BLK <= `la` < BASE_BLK + WIN_BLOCKS. The value of `sa` never changes the select or the hit.
- R2: While `bale` is high, `memcs16_n` is the combinational inverse of the live R1 decode of `la`. A change of `la` shows on it within the same clock period.
- R3: While `bale` is low, `memcs16_n` drives the inverse of the recorded hit. It does not respond to changes of `la` until `bale` rises again.
- R4: On every rising clock edge at which `bale` is high, `win_hit` takes the R1 decode of `la`. While `bale` is low, `win_hit` holds.
- R5: On every rising clock edge at which `bale` is high, `loc_addr` takes {(`la` − BASE_BLK) modulo 2^BLK_W, `sa[16:0]`}. The block bits are the upper bits and `sa[16:0]` the low 17. The value is held while `bale` is low, so it is the last one before the strobe fell, even if `sa` changed late.
- R6: `arr_rd_en` is high exactly when `win_hit` is 1 and `memr_n` is 0. `arr_wr_en` is high exactly when `win_hit` is 1 and `memw_n` is 0.
- R7: With the 16-bit parameter cleared (8-bit window), `memcs16_n` stays 1 in every cycle, while `win_hit` and `loc_addr` still follow R4 and R5.
- R8: While reset is asserted, and for two rising edges after `rst_n` goes high, `win_hit` is 0, `loc_addr` is 0 and `memcs16_n` is 1.
- R9: For any `la` outside the window, `memcs16_n` stays 1, both while `bale` is high and after it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bale | input | 1 | Address-latch strobe, high while the early address is valid |
| la | input | 7 | Unlatched upper address, bits 23:17 |
| sa | input | 20 | System address, bits 19:0 |
| memr_n | input | 1 | Active-low memory read strobe |
| memw_n | input | 1 | Active-low memory write strobe |
| memcs16_n | output | 1 | Active-low 16-bit memory chip select |
| win_hit | output | 1 | Recorded window hit for the current cycle |
| loc_addr | output | BLK_W+17 | Recorded card-local address |
| arr_rd_en | output | 1 | Array read enable |
| arr_wr_en | output | 1 | Array write enable |

## Verification
Bus cycles are run with `sa` changed late in the strobe-high phase. This separates a design that records the address at the last strobe-high edge from one that keeps the first value. It also shows that `sa` never moves the select. After `bale` falls, `la` is moved into and out of the window, which tells a held select apart from one that still follows the live decode. A full sweep of all 128 block indices with the strobe high, and quick `la` toggles within one clock period, confirm the exact window edges and the combinational path. An 8-bit instance runs alongside to show the select stays high while the hit is still recorded.

// File: rtl/isa_win_pkg.sv
package isa_win_pkg;

  localparam int unsigned BLK_SHIFT = 17;  // 128 KB granularity
  localparam int unsigned LA_W      = 7;   // address bits 23:17

  function automatic logic blk_in_window(input logic [LA_W-1:0] blk,
                                         input int unsigned base,
                                         input int unsigned nblk);
    int unsigned v;
    v = int'(blk);
    return (v >= base) && (v < base + nblk);
  endfunction

endpackage

// File: rtl/isa_rst_sync.sv
module isa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/isa_la_decode.sv
module isa_la_decode
  import isa_win_pkg::*;
#(
  parameter int unsigned BASE_BLK   = 6,
  parameter int unsigned WIN_BLOCKS = 2,
  parameter int unsigned BLK_W      = 1
) (
  input  logic [LA_W-1:0]  la,
  output logic             hit,
  output logic [BLK_W-1:0] blk_idx
);
  logic [LA_W:0] diff;

  always_comb begin
    hit     = blk_in_window(la, BASE_BLK, WIN_BLOCKS);
    diff    = {1'b0, la} - (LA_W+1)'(BASE_BLK);
    blk_idx = diff[BLK_W-1:0];
  end
endmodule

// File: rtl/isa_cycle_latch.sv
module isa_cycle_latch
  import isa_win_pkg::*;
#(
  parameter int unsigned BLK_W = 1,
  localparam int unsigned LOC_W = BLK_W + BLK_SHIFT
) (
  input  logic                 clk,
  input  logic                 rst_sync_n,
  input  logic                 bale,
  input  logic                 hit_live,
  input  logic [BLK_W-1:0]     blk_idx,
  input  logic [BLK_SHIFT-1:0] sa_low,
  output logic                 hit_q,
  output logic [LOC_W-1:0]     loc_q
);
  logic             hit_d;
  logic [LOC_W-1:0] loc_d;
  logic             cap_en;

  assign cap_en = bale;

  always_comb begin
    hit_d = hit_q;
    loc_d = loc_q;
    if (cap_en) begin
      hit_d = hit_live;
      loc_d = {blk_idx, sa_low};
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hit_q <= 1'b0;
      loc_q <= '0;
    end else begin
      hit_q <= hit_d;
      loc_q <= loc_d;
    end
  end

  // Recorded state holds while the strobe is low
  assert_hold_when_low_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bale |=> ($stable(hit_q) && $stable(loc_q)));

  // A new hit can only appear after a strobe-high edge
  assert_hit_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(hit_q) |-> $past(bale));
endmodule

// File: rtl/isa_mem16_window.sv
module isa_mem16_window
  import isa_win_pkg::*;
#(
  parameter int unsigned BASE_BLK   = 6,
  parameter int unsigned WIN_BLOCKS = 2,
  parameter bit          IS16       = 1'b1,
  localparam int unsigned BLK_W = (WIN_BLOCKS > 1) ? $clog2(WIN_BLOCKS) : 1,
  localparam int unsigned LOC_W = BLK_W + BLK_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bale,
  input  logic [LA_W-1:0]  la,
  input  logic [19:0]      sa,
  input  logic             memr_n,
  input  logic             memw_n,
  output logic             memcs16_n,
  output logic             win_hit,
  output logic [LOC_W-1:0] loc_addr,
  output logic             arr_rd_en,
  output logic             arr_wr_en
);
  logic             rst_sync_n;
  logic             hit_live;
  logic [BLK_W-1:0] blk_idx;
  logic             hit_q;
  logic             sel_hit;
  logic             cs_drive;
  logic [2:0]       sa_hi_unused;

  assign sa_hi_unused = sa[19:BLK_SHIFT];

  isa_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  isa_la_decode #(
    .BASE_BLK   (BASE_BLK),
    .WIN_BLOCKS (WIN_BLOCKS),
    .BLK_W      (BLK_W)
  ) u_decode (
    .la      (la),
    .hit     (hit_live),
    .blk_idx (blk_idx)
  );

  isa_cycle_latch #(
    .BLK_W (BLK_W)
  ) u_latch (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .bale       (bale),
    .hit_live   (hit_live),
    .blk_idx    (blk_idx),
    .sa_low     (sa[BLK_SHIFT-1:0]),
    .hit_q      (hit_q),
    .loc_q      (loc_addr)
  );

  // Live decode while the early address is valid, recorded hit afterwards
  assign sel_hit = bale ? hit_live : hit_q;

  generate
    if (IS16) begin : g_wide
      assign cs_drive = sel_hit;
    end else begin : g_narrow
      assign cs_drive = 1'b0;
      assert_never_select_R7: assert property (@(posedge clk) memcs16_n);
    end
  endgenerate

  assign memcs16_n = ~(rst_sync_n & cs_drive);
  assign win_hit   = hit_q;
  assign arr_rd_en = hit_q & ~memr_n;
  assign arr_wr_en = hit_q & ~memw_n;

  // Select frozen across a strobe-low stretch
  assert_cs_frozen_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!bale && $past(!bale) && $past(rst_sync_n)) |-> $stable(memcs16_n));

  // Array enables only inside a hit cycle
  assert_array_gated_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !win_hit |-> (!arr_rd_en && !arr_wr_en));

  // Reset leaves the card silent
  assert_reset_quiet_R8: assert property (@(posedge clk)
    !rst_sync_n |-> (memcs16_n && !win_hit && (loc_addr == '0)));

  // Select low implies the recorded or live decode hit
  assert_cs_needs_hit_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !memcs16_n |-> (bale || win_hit));
endmodule

// File: tb/test_isa_mem16_window.sv
`timescale 1ns/1ps
module test_isa_mem16_window;

  localparam int BASE = 6;
  localparam int NBLK = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bale;
  logic [6:0]  la;
  logic [19:0] sa;
  logic        memr_n, memw_n;

  logic        cs_n, hit, rd_en, wr_en;
  logic [17:0] loc;
  logic        cs8_n, hit8, rd8, wr8;
  logic [17:0] loc8;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  isa_mem16_window #(.BASE_BLK(BASE), .WIN_BLOCKS(NBLK), .IS16(1'b1)) i_isa_mem16_window (
    .clk(clk), .rst_n(rst_n), .bale(bale), .la(la), .sa(sa),
    .memr_n(memr_n), .memw_n(memw_n), .memcs16_n(cs_n), .win_hit(hit),
    .loc_addr(loc), .arr_rd_en(rd_en), .arr_wr_en(wr_en));

  isa_mem16_window #(.BASE_BLK(BASE), .WIN_BLOCKS(NBLK), .IS16(1'b0)) i_isa_mem16_window_8b (
    .clk(clk), .rst_n(rst_n), .bale(bale), .la(la), .sa(sa),
    .memr_n(memr_n), .memw_n(memw_n), .memcs16_n(cs8_n), .win_hit(hit8),
    .loc_addr(loc8), .arr_rd_en(rd8), .arr_wr_en(wr8));

  // ---------------- reference model ----------------
  int          m_cnt = 0;
  bit          m_hit = 1'b0;
  logic [17:0] m_loc = '0;

  function automatic bit in_win(input logic [6:0] b);
    return (int'(b) >= BASE) && (int'(b) < BASE + NBLK);
  endfunction

  function automatic logic [17:0] loc_of(input logic [6:0] b, input logic [19:0] a);
    int rel;
    rel = (int'(b) - BASE) & 1;
    return {rel[0], a[16:0]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_hit = 1'b0; m_loc = '0;
    end else begin
      if (m_cnt < 2) begin
        m_hit = 1'b0; m_loc = '0;
        m_cnt++;
      end else if (bale) begin
        m_hit = in_win(la);
        m_loc = loc_of(la, sa);
      end
    end
  end

  function automatic bit exp_cs();
    bit sel;
    sel = bale ? in_win(la) : m_hit;
    return !((m_cnt == 2) && sel);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      chk("R2/R3 cs", 32'(cs_n), 32'(exp_cs()));
      chk("R4 hit", 32'(hit), 32'(m_hit));
      chk("R5 loc", 32'(loc), 32'(m_loc));
      chk("R6 rd", 32'(rd_en), 32'(m_hit && !memr_n));
      chk("R6 wr", 32'(wr_en), 32'(m_hit && !memw_n));
      chk("R7 cs8", 32'(cs8_n), 32'h1);
      chk("R7 hit8", 32'(hit8), 32'(m_hit));
      chk("R7 loc8", 32'(loc8), 32'(m_loc));
    end
  end

  task automatic report();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    report();
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  // one bus cycle: early/late SA, strobe, garbage LA after fall
  task automatic bus_cycle(input logic [6:0] b, input logic [19:0] sa_e,
                           input logic [19:0] sa_l, input bit rd, input bit wr,
                           input logic [6:0] b_after);
    bale = 1'b1; la = b; sa = sa_e;
    step();
    sa = sa_l;
    step();
    bale = 1'b0; la = b_after;
    #1;
    chk("R3 cs after fall", 32'(cs_n), 32'(!in_win(b)));
    chk("R5 late sa", 32'(loc), 32'(loc_of(b, sa_l)));
    memr_n = !rd; memw_n = !wr;
    step();
    la = b; sa = 20'hFFFFF;
    #1;
    chk("R1 sa ignored", 32'(cs_n), 32'(!in_win(b)));
    la = b_after ^ 7'h01;
    #1;
    chk("R3 la ignored", 32'(cs_n), 32'(!in_win(b)));
    chk("R6 strobe", 32'(rd_en | wr_en), 32'(in_win(b) && (rd || wr)));
    step();
    memr_n = 1'b1; memw_n = 1'b1;
    step();
  endtask

  initial begin
    rst_n = 1'b0; bale = 1'b0; la = 7'h06; sa = '0; memr_n = 1'b1; memw_n = 1'b1;
    step(); step();
    bale = 1'b1;
    #1;
    chk("R8 reset cs", 32'(cs_n), 32'h1);
    chk("R8 reset hit", 32'(hit), 32'h0);
    step();
    bale = 1'b0;
    rst_n = 1'b1;
    step();
    #1;
    chk("R8 sync release cs", 32'(cs_n), 32'h1);
    step(); step();

    bus_cycle(7'd6, 20'h12345, 20'hC1234, 1'b1, 1'b0, 7'h7F);
    bus_cycle(7'd7, 20'h00000, 20'hEABCD, 1'b0, 1'b1, 7'd6);
    bus_cycle(7'd5, 20'h11111, 20'hBFFFF, 1'b1, 1'b0, 7'd6);
    bus_cycle(7'd8, 20'h22222, 20'h00001, 1'b0, 1'b1, 7'd7);
    bus_cycle(7'd6, 20'h3FFFF, 20'h1FFFF, 1'b1, 1'b1, 7'd0);

    // R2: live LA toggles within one strobe-high period
    bale = 1'b1; la = 7'd6;
    #1 chk("R2 live in", 32'(cs_n), 32'h0);
    la = 7'd9;
    #1 chk("R2 live out", 32'(cs_n), 32'h1);
    la = 7'd7;
    #1 chk("R2 live in2", 32'(cs_n), 32'h0);
    step();

    // R9 / R1 edges: sweep all block indices with strobe high
    for (int b = 0; b < 128; b++) begin
      la = 7'(b); sa = 20'(b * 4099);
      #1 chk(in_win(7'(b)) ? "R1 sweep in" : "R9 sweep out", 32'(cs_n), 32'(!in_win(7'(b))));
      step();
    end
    bale = 1'b0; la = 7'd6;
    step();
    #1 chk("R9 held miss", 32'(cs_n), 32'h1);
    step(); step();
    report();
  end
endmodule